// File: doc/BRIEF.md
# Presence-Detect Serial EEPROM Slave

This block models the small configuration memory that a memory module exposes on a two-wire serial bus. It holds 256 bytes. The lower 128 bytes come from a content table fixed at build time and cannot be written. The upper 128 bytes belong to the host. The device answers at a 7-bit address whose top nibble is fixed and whose low three bits come from strap pins, so up to eight of these slaves can share one bus.

SCL and SDA enter as plain inputs and are oversampled on a faster system clock. The data line is driven only through an active-high pull-low enable, which models an open-drain output with an external pull-up. The block decodes START and STOP conditions and handles single-byte and multi-byte writes. It serves random reads (address write, repeated START, read) and sequential reads, with an address counter that increments after every byte.

After reset, a short background scan adds bytes 0 to 62 of the fixed table. It compares the low eight bits of that sum with byte 63 and raises a sticky flag on a mismatch.

Top module: `pd_eeprom_slave`

## Requirements
- R1: After reset, SDA is released (`sda_oe_o` low), `csum_bad_o` is low, and every upper-half byte reads 0x00.
- R2: A START followed by the byte {1010, strap_i[2:0], R/W} is ACKed. Any other address byte is NACKed, and SDA then stays released through later bytes until the next START.
- R3: A write of data to address 128..255 stores the byte, and a later read of that address returns it.
- R4: A write to address 0..127 is ACKed but the data is discarded. The address counter still advances, so the next byte of a multi-byte write lands at the following address.
- R5: Byte 0 reads 0x80 and byte 1 reads 0x08. Byte i for 2 ≤ i ≤ 62 reads (37·i + 5) mod 256. Byte 63 reads the low 8 bits of the sum of bytes 0..62. Bytes 64..127 read 0x00.
- R6: A read continues with the next address after every master ACK, and stops on a master NACK. The address wraps from 255 to 0 for both reads and writes.
- R7: Within 70 clock cycles of reset release, `csum_bad_o` shows whether byte 63 differs from the sum of bytes 0..62. It stays high until the next reset once set, and it stays low when the table is consistent.
- R8: A STOP at any point, including in the middle of a byte, returns the slave to idle. A partially received data byte is not written.
- R9: A repeated START, given without a STOP, restarts the device-address phase.
- R10: The slave's ACK appears as SDA low during the ninth clock of each byte it accepts, and SDA changes only while SCL is low.
- R11: After a master NACK on a read byte, the slave releases SDA and ignores further clocks until a new START.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired-AND bus) |
| strap_i | input | 3 | Strap pins setting the low three address bits |
| sda_oe_o | output | 1 | High pulls SDA low; low releases it |
| csum_bad_o | output | 1 | Sticky flag: byte 63 does not match its range sum |

## Verification
The bench sweeps every strap setting against every low-address value. A decoder that ignored a strap bit would ACK a foreign address, and one that failed to release after a NACK would pull the next byte low.

Writes that straddle the 127/128 boundary and the 255/0 wrap are checked, along with a write aimed at the checksum byte. A slave that stored into the locked half, or stopped advancing the counter on a discarded byte, would corrupt its neighbours. A full 256-byte sequential read then compares every address against the arithmetic table and the written bytes.

A STOP in the middle of a byte, a repeated START, and clocks after a read NACK are each applied. A slave that committed half a byte, lost the restarted address phase or kept driving after a NACK would show a wrong value on the line. A second instance with a corrupted checksum byte must raise the flag, and the normal instance must keep it low.

// File: rtl/pd_eeprom_pkg.sv
package pd_eeprom_pkg;

  typedef enum logic [2:0] {
    PS_IDLE,
    PS_DEV,
    PS_WADR,
    PS_WDAT,
    PS_RDAT
  } pd_state_e;

  // Arithmetic fill for the table body
  function automatic logic [7:0] pd_fill(input int unsigned idx,
                                         input int unsigned mul,
                                         input int unsigned seed);
    return 8'((idx * mul + seed) % 256);
  endfunction

  // Table bytes below the checksum slot
  function automatic logic [7:0] pd_body(input int unsigned idx,
                                         input int unsigned mul,
                                         input int unsigned seed);
    if (idx == 0)      return 8'h80;
    else if (idx == 1) return 8'h08;
    else               return pd_fill(idx, mul, seed);
  endfunction

  // Low 8 bits of the sum of table bytes 0 .. csum_idx-1
  function automatic logic [7:0] pd_sum(input int unsigned csum_idx,
                                        input int unsigned mul,
                                        input int unsigned seed);
    logic [7:0] acc;
    acc = 8'h00;
    for (int unsigned i = 0; i < csum_idx; i++) acc = acc + pd_body(i, mul, seed);
    return acc;
  endfunction

  // Full lower-half content
  function automatic logic [7:0] pd_lower(input int unsigned idx,
                                          input int unsigned mul,
                                          input int unsigned seed,
                                          input int unsigned csum_idx,
                                          input logic [7:0]  csum);
    if (idx < csum_idx)       return pd_body(idx, mul, seed);
    else if (idx == csum_idx) return csum;
    else                      return 8'h00;
  endfunction

endpackage

// File: rtl/pd_bus_sync.sv
module pd_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe, scl_pipe_n;
  logic [STAGES-1:0] sda_pipe, sda_pipe_n;
  logic              scl_q, sda_q;

  always_comb begin
    scl_pipe_n = {scl_pipe[STAGES-2:0], scl_i};
    sda_pipe_n = {sda_pipe[STAGES-2:0], sda_i};
  end

  // Idle bus level is high on both lines
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= scl_pipe_n;
      sda_pipe <= sda_pipe_n;
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/pd_store.sv
module pd_store
  import pd_eeprom_pkg::*;
#(
  parameter int         DEPTH     = 256,
  parameter int         CSUM_IDX  = 63,
  parameter int         FILL_MUL  = 37,
  parameter int         FILL_SEED = 5,
  parameter logic [7:0] CSUM_XOR  = 8'h00,
  localparam int        AW        = $clog2(DEPTH),
  localparam int        HALF      = DEPTH / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata,
  input  logic [AW-2:0] scan_addr,
  output logic [7:0]    scan_data
);

  localparam logic [7:0] CSUM_VAL =
    pd_sum(CSUM_IDX, FILL_MUL, FILL_SEED) ^ CSUM_XOR;

  logic [HALF*8-1:0] upper_flat;

  // One enabled byte register per writable location
  for (genvar g = 0; g < HALF; g++) begin : g_upper
    logic [7:0] q;
    logic       hit;
    assign hit = we && (waddr == AW'(HALF + g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 8'h00;
      else if (hit) q <= wdata;
    end
    assign upper_flat[g*8 +: 8] = q;
  end

  always_comb begin
    if (raddr[AW-1])
      rdata = upper_flat[raddr[AW-2:0]*8 +: 8];
    else
      rdata = pd_lower(32'(raddr[AW-2:0]), FILL_MUL, FILL_SEED, CSUM_IDX, CSUM_VAL);
  end

  assign scan_data = pd_lower(32'(scan_addr), FILL_MUL, FILL_SEED, CSUM_IDX, CSUM_VAL);

endmodule

// File: rtl/pd_csum_scan.sv
module pd_csum_scan #(
  parameter int  CSUM_IDX = 63,
  parameter int  IW       = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [IW-1:0] scan_addr,
  input  logic [7:0]    scan_data,
  output logic          done,
  output logic          bad
);

  logic [IW-1:0] idx, idx_n;
  logic [7:0]    acc, acc_n;
  logic          done_n, bad_n;

  always_comb begin
    idx_n  = idx;
    acc_n  = acc;
    done_n = done;
    bad_n  = bad;
    if (!done) begin
      if (idx == IW'(CSUM_IDX)) begin
        bad_n  = (acc != scan_data);
        done_n = 1'b1;
      end else begin
        acc_n = acc + scan_data;
        idx_n = idx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx  <= '0;
      acc  <= 8'h00;
      done <= 1'b0;
      bad  <= 1'b0;
    end else begin
      idx  <= idx_n;
      acc  <= acc_n;
      done <= done_n;
      bad  <= bad_n;
    end
  end

  assign scan_addr = idx;

endmodule

// File: rtl/pd_link_fsm.sv
module pd_link_fsm
  import pd_eeprom_pkg::*;
#(
  parameter int         AW       = 8,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          sda_s,
  input  logic [2:0]    strap,
  input  logic [7:0]    rd_data,
  output logic [AW-1:0] addr_o,
  output logic          we_o,
  output logic [7:0]    wdata_o,
  output logic          sda_oe,
  output logic          sel_o
);

  pd_state_e     state, state_n;
  logic [3:0]    cnt, cnt_n;
  logic [7:0]    rx, rx_n;
  logic [7:0]    tx, tx_n;
  logic [AW-1:0] addr, addr_n;
  logic          rw, rw_n;
  logic          oe_n;
  logic          we_n;

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    rx_n    = rx;
    tx_n    = tx;
    addr_n  = addr;
    rw_n    = rw;
    oe_n    = sda_oe;
    we_n    = 1'b0;
    if (stop_det) begin
      state_n = PS_IDLE;
      cnt_n   = 4'd0;
      oe_n    = 1'b0;
    end else if (start_det) begin
      state_n = PS_DEV;
      cnt_n   = 4'd0;
      oe_n    = 1'b0;
    end else begin
      case (state)
        PS_DEV, PS_WADR, PS_WDAT: begin
          if (scl_rise && cnt < 4'd8) begin
            rx_n  = {rx[6:0], sda_s};
            cnt_n = cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            cnt_n = 4'd9;
            if (state == PS_DEV) begin
              if (rx[7:1] == {DEV_CODE, strap}) begin
                oe_n = 1'b1;
                rw_n = rx[0];
              end else begin
                state_n = PS_IDLE;
                cnt_n   = 4'd0;
              end
            end else if (state == PS_WADR) begin
              oe_n   = 1'b1;
              addr_n = rx[AW-1:0];
            end else begin
              oe_n   = 1'b1;
              we_n   = addr[AW-1];
              addr_n = addr + 1'b1;
            end
          end else if (scl_fall && cnt == 4'd9) begin
            cnt_n = 4'd0;
            oe_n  = 1'b0;
            if (state == PS_DEV) begin
              if (rw) begin
                state_n = PS_RDAT;
                tx_n    = rd_data;
                oe_n    = ~rd_data[7];
              end else begin
                state_n = PS_WADR;
              end
            end else if (state == PS_WADR) begin
              state_n = PS_WDAT;
            end
          end
        end
        PS_RDAT: begin
          if (scl_fall && cnt < 4'd7) begin
            cnt_n = cnt + 4'd1;
            tx_n  = {tx[6:0], 1'b0};
            oe_n  = ~tx[6];
          end else if (scl_fall && cnt == 4'd7) begin
            cnt_n = 4'd8;
            oe_n  = 1'b0;
          end else if (scl_rise && cnt == 4'd8) begin
            addr_n = addr + 1'b1;
            if (sda_s) begin
              state_n = PS_IDLE;
              cnt_n   = 4'd0;
            end else begin
              cnt_n = 4'd9;
            end
          end else if (scl_fall && cnt == 4'd9) begin
            cnt_n = 4'd0;
            tx_n  = rd_data;
            oe_n  = ~rd_data[7];
          end
        end
        default: begin
          cnt_n = 4'd0;
          oe_n  = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= PS_IDLE;
      cnt    <= 4'd0;
      rx     <= 8'h00;
      tx     <= 8'h00;
      addr   <= '0;
      rw     <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      state  <= state_n;
      cnt    <= cnt_n;
      rx     <= rx_n;
      tx     <= tx_n;
      addr   <= addr_n;
      rw     <= rw_n;
      sda_oe <= oe_n;
    end
  end

  assign we_o    = we_n;
  assign wdata_o = rx;
  assign addr_o  = addr;
  assign sel_o   = (state != PS_IDLE);

endmodule

// File: rtl/pd_eeprom_slave.sv
module pd_eeprom_slave #(
  parameter int         DEPTH       = 256,
  parameter int         CSUM_IDX    = 63,
  parameter int         FILL_MUL    = 37,
  parameter int         FILL_SEED   = 5,
  parameter logic [7:0] CSUM_XOR    = 8'h00,
  parameter logic [3:0] DEV_CODE    = 4'b1010,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  output logic       sda_oe_o,
  output logic       csum_bad_o
);

  localparam int AW = $clog2(DEPTH);

  logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [AW-1:0] link_addr;
  logic          link_we, link_sel;
  logic [7:0]    link_wdata, link_rdata;
  logic [AW-2:0] scan_addr;
  logic [7:0]    scan_data;
  logic          scan_done;

  pd_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  pd_link_fsm #(.AW(AW), .DEV_CODE(DEV_CODE)) u_link (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_s     (sda_s),
    .strap     (strap_i),
    .rd_data   (link_rdata),
    .addr_o    (link_addr),
    .we_o      (link_we),
    .wdata_o   (link_wdata),
    .sda_oe    (sda_oe_o),
    .sel_o     (link_sel)
  );

  pd_store #(
    .DEPTH     (DEPTH),
    .CSUM_IDX  (CSUM_IDX),
    .FILL_MUL  (FILL_MUL),
    .FILL_SEED (FILL_SEED),
    .CSUM_XOR  (CSUM_XOR)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (link_we),
    .waddr     (link_addr),
    .wdata     (link_wdata),
    .raddr     (link_addr),
    .rdata     (link_rdata),
    .scan_addr (scan_addr),
    .scan_data (scan_data)
  );

  pd_csum_scan #(.CSUM_IDX(CSUM_IDX), .IW(AW-1)) u_scan (
    .clk       (clk),
    .rst_n     (rst_n),
    .scan_addr (scan_addr),
    .scan_data (scan_data),
    .done      (scan_done),
    .bad       (csum_bad_o)
  );

endmodule

// File: rtl/pd_eeprom_slave_chk.sv
module pd_eeprom_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic sda_oe,
  input logic stop_det,
  input logic sel,
  input logic csum_done,
  input logic csum_bad
);

  // R10
  sda_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  // R8
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!sda_oe && !sel));

  // R2
  drive_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> sel);

  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csum_bad |=> csum_bad);

  // R1
  flag_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !csum_done |-> !csum_bad);

endmodule

bind pd_eeprom_slave pd_eeprom_slave_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_s     (scl_s),
  .sda_oe    (sda_oe_o),
  .stop_det  (stop_det),
  .sel       (link_sel),
  .csum_done (scan_done),
  .csum_bad  (csum_bad_o)
);

// File: tb/pd_eeprom_slave_test.sv
module pd_eeprom_slave_test;

  localparam int CLK_PERIOD = 10;
  localparam int HQ         = 6;

  logic       clk;
  logic       rst_n;
  logic       m_scl;
  logic       m_low;
  logic [2:0] strap;
  logic       sda_oe;
  logic       csum_bad;
  logic       alt_oe;
  logic       alt_bad;
  wire        sda_line = ~(m_low | sda_oe);

  int         n_checks = 0;
  int         n_err    = 0;
  bit         finished = 0;
  logic [7:0] exp_mem [256];

  pd_eeprom_slave uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (m_scl),
    .sda_i      (sda_line),
    .strap_i    (strap),
    .sda_oe_o   (sda_oe),
    .csum_bad_o (csum_bad)
  );

  pd_eeprom_slave #(.CSUM_XOR(8'h01)) uut_alt (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (1'b1),
    .sda_i      (1'b1),
    .strap_i    (3'd0),
    .sda_oe_o   (alt_oe),
    .csum_bad_o (alt_bad)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  endtask

  task automatic bus_start();
    m_low = 1'b0; wclk(HQ);
    m_scl = 1'b1; wclk(HQ);
    m_low = 1'b1; wclk(HQ);
    m_scl = 1'b0; wclk(HQ);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; wclk(HQ);
    m_scl = 1'b1; wclk(HQ);
    m_low = 1'b0; wclk(2*HQ);
  endtask

  task automatic bit_out(input logic b);
    m_low = ~b;   wclk(HQ);
    m_scl = 1'b1; wclk(2*HQ);
    m_scl = 1'b0; wclk(HQ);
  endtask

  task automatic bit_in(output logic b);
    m_low = 1'b0; wclk(HQ);
    m_scl = 1'b1; wclk(HQ);
    b = sda_line; wclk(HQ);
    m_scl = 1'b0; wclk(HQ);
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(b);
    acked = ~b;
  endtask

  task automatic rd_byte(output logic [7:0] d, input logic give_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      bit_in(b);
      d[i] = b;
    end
    bit_out(~give_ack);
  endtask

  // Multi-byte write starting at a; bytes taken from the low end of data
  task automatic wr_seq(input string tag, input logic [7:0] a,
                        input logic [31:0] data, input int n);
    logic       ack;
    logic [7:0] p;
    bus_start();
    wr_byte({4'hA, strap, 1'b0}, ack); chk({tag, " R10 dev ack"}, ack, 1);
    wr_byte(a, ack);                   chk({tag, " R10 addr ack"}, ack, 1);
    p = a;
    for (int k = 0; k < n; k++) begin
      wr_byte(data[k*8 +: 8], ack);
      chk({tag, " R4 data ack"}, ack, 1);
      if (p[7]) exp_mem[p] = data[k*8 +: 8];
      p = p + 8'd1;
    end
    bus_stop();
  endtask

  // Random read of n bytes starting at a, NACK on the last
  task automatic rd_seq(input string tag, input logic [7:0] a, input int n);
    logic       ack;
    logic [7:0] d;
    logic [7:0] p;
    bus_start();
    wr_byte({4'hA, strap, 1'b0}, ack); chk({tag, " R10 dev ack"}, ack, 1);
    wr_byte(a, ack);                   chk({tag, " R10 addr ack"}, ack, 1);
    bus_start();
    wr_byte({4'hA, strap, 1'b1}, ack); chk({tag, " R9 restart ack"}, ack, 1);
    p = a;
    for (int k = 0; k < n; k++) begin
      rd_byte(d, k != n - 1);
      chk($sformatf("%s byte %0h", tag, p), d, exp_mem[p]);
      p = p + 8'd1;
    end
  endtask

  initial begin
    wclk(190000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] sum;
    logic       ack, b;
    logic [7:0] d;

    // Reference table computed arithmetically
    sum = 8'h00;
    for (int i = 0; i < 256; i++) begin
      if (i == 0)       exp_mem[i] = 8'h80;
      else if (i == 1)  exp_mem[i] = 8'h08;
      else if (i < 63)  exp_mem[i] = 8'((37 * i + 5) % 256);
      else              exp_mem[i] = 8'h00;
      if (i < 63) sum = sum + exp_mem[i];
    end
    exp_mem[63] = sum;

    rst_n = 1'b0;
    m_scl = 1'b1;
    m_low = 1'b0;
    strap = 3'd5;
    wclk(5);
    chk("R1 sda released in reset", sda_oe, 0);
    chk("R1 flag low in reset", csum_bad, 0);
    rst_n = 1'b1;
    wclk(70);
    chk("R7 consistent table flag", csum_bad, 0);
    chk("R7 corrupted table flag", alt_bad, 1);
    chk("R1 sda released after reset", sda_oe, 0);

    // R2: strap against every low address value
    for (int s = 0; s < 8; s++) begin
      strap = 3'(s);
      for (int a = 0; a < 8; a++) begin
        bus_start();
        wr_byte({4'hA, 3'(a), 1'b0}, ack);
        chk($sformatf("R2 strap %0d addr %0d", s, a), ack, int'(a == s));
        if (a != s) begin
          wr_byte(8'h00, ack);
          chk("R2 released after mismatch", ack, 0);
        end
        bus_stop();
      end
    end
    strap = 3'd5;
    bus_start();
    wr_byte({4'hB, strap, 1'b0}, ack);
    chk("R2 wrong fixed nibble", ack, 0);
    bus_stop();

    // R1: untouched upper bytes read zero
    rd_seq("R1 upper zero", 8'hA0, 2);
    bus_stop();

    // R3: single byte write in the upper half
    wr_seq("R3 write", 8'h80, 32'h0000_003C, 1);
    // R4: straddle the locked boundary
    wr_seq("R4 straddle", 8'h7E, 32'hA4A3_A2A1, 4);
    // R6: write wraps from 255 into the locked bytes
    wr_seq("R6 wrap write", 8'hFE, 32'h1122_A55A, 4);
    // R4: attempt to overwrite the checksum byte
    wr_seq("R4 csum byte", 8'h3F, 32'h0000_0000, 1);
    chk("R4 flag after locked write", csum_bad, 0);

    // R8: STOP in the middle of a data byte
    bus_start();
    wr_byte({4'hA, strap, 1'b0}, ack);
    wr_byte(8'h90, ack);
    for (int i = 0; i < 4; i++) bit_out(1'b1);
    bus_stop();
    rd_seq("R8 partial byte", 8'h90, 1);
    bus_stop();

    // R9 and R5: random read via repeated START
    rd_seq("R5 random read", 8'h05, 1);
    bus_stop();

    // R6 and R11: sequential read across the wrap, then clocks after NACK
    rd_seq("R6 wrap read", 8'hFE, 5);
    bit_in(b);
    chk("R11 released after NACK", b, 1);
    bit_in(b);
    chk("R11 still released", b, 1);
    bus_stop();

    // R5/R3/R4/R6: sweep the whole memory in one read
    rd_seq("R5 sweep", 8'h00, 256);
    bus_stop();

    chk("R7 flag after traffic", csum_bad, 0);
    chk("R7 corrupted flag held", alt_bad, 1);
    finish_run();
  end

endmodule